// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns a microcontroller address into a single chip select for the on-chip memories of a peripheral companion device. There are seven select targets: four code-memory blocks, one scratch SRAM, one internal I/O window and one peripheral I/O window. Each target owns a small set of configuration registers: a base, a mask and an enable bit. Software loads these through a one-word register-write port. Address decoding is purely combinational on top of those registers, so a select follows the address in the same cycle.

Data regions (the SRAM and both I/O windows) may lie on top of a code block. Where they do, the data region wins and that slice of code memory cannot be reached. Code blocks must not overlap each other, and data regions must not overlap each other. A code window must also not be wider than one physical code block. The block flags each of these configuration faults. When it does, it still picks a single winner by fixed priority. Alongside the select it produces the offset of the address inside the chosen region. In 16-bit bus mode that offset is a word offset, so the same byte window addresses half as many 16-bit words.

The block has no state machine. Its only sequential part is the register file, which has two states per region: disabled (after reset) and enabled (after an enable write).

Top module: `csd_decoder`

## Requirements
- R1: After reset every region is disabled and every base and mask is zero. With `dec_en`=1 no select is active, `no_sel`=1, and all three error flags are 0.
- R2: A region hits when it is enabled and (`addr` & mask) == base.
- R3: `err_code_ovl`=1 when two enabled code regions i<j overlap. Regions overlap when (base & ~mask)==0 holds for both and ((base_i ^ base_j) & mask_i & mask_j)==0. When several code regions hit, only the lowest-numbered one is selected.
- R4: When any data region hits, no code select is active.
- R5: `err_data_ovl`=1 when two participating data regions overlap, using the R3 rule. Among hitting data regions the priority is SRAM, then internal I/O, then peripheral I/O.
- R6: The peripheral I/O region neither hits nor takes part in the overlap check while `periph_mode`=0.
- R7: `err_code_size`=1 when an enabled code region has more than log2(CODE_BLK_KB*1024) zero bits in its mask.
- R8: `offset` = (`addr` & ~mask of the selected region), shifted right by one when `bus16`=1. It is zero when nothing is selected.
- R9: While `dec_en`=0 all selects and `no_sel` are 0.
- R10: `no_sel`=1 exactly when `dec_en`=1 and no region hits.
- R11: At most one of the seven selects is active at any time.
- R12: A write with `cfg_we`=1 updates the register named by `cfg_idx` and `cfg_field`, and takes effect from the next clock. `cfg_idx` codes: 0-3 are code blocks, 4 is SRAM, 5 is internal I/O, 6 is peripheral I/O, and 7 is ignored. `cfg_field` codes: 0 is base, 1 is mask, 2 is enable (`cfg_wdata[0]`), and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Region index of the write |
| cfg_field | input | 2 | Field of the write (base, mask, enable) |
| cfg_wdata | input | ADDR_W | Write data |
| dec_en | input | 1 | Global decode enable |
| bus16 | input | 1 | 1 selects 16-bit bus mode (word offsets) |
| periph_mode | input | 1 | 1 makes the peripheral I/O window active |
| addr | input | ADDR_W | Host byte address |
| code_sel | output | 4 | Code-block selects, bit i for block i |
| sram_sel | output | 1 | SRAM select |
| iio_sel | output | 1 | Internal I/O select |
| pio_sel | output | 1 | Peripheral I/O select |
| no_sel | output | 1 | Enabled decode that hit nothing |
| offset | output | ADDR_W | Offset of the address inside the selected region |
| err_code_ovl | output | 1 | Code regions overlap |
| err_data_ovl | output | 1 | Data regions overlap |
| err_code_size | output | 1 | A code window is larger than one block |

## Verification
A corrupted base, mask or enable bit is visible one clock after the write that caused it. It shows up as a select, `no_sel` or offset that differs from the model for any address inside or next to that region. The error flags show it as well, since they are a pure function of the registers. A fault in the priority network appears in the same cycle as the address, but only for addresses where two or more regions hit. The bench therefore steers about half of its random addresses into configured windows, and it builds overlaps on purpose in the directed cases.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int NREG  = 7;
    localparam int NCODE = 4;

    typedef enum logic [2:0] {
        RG_CODE0 = 3'd0,
        RG_CODE1 = 3'd1,
        RG_CODE2 = 3'd2,
        RG_CODE3 = 3'd3,
        RG_SRAM  = 3'd4,
        RG_IIO   = 3'd5,
        RG_PIO   = 3'd6,
        RG_NONE  = 3'd7
    } region_e;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_MASK = 2'd1,
        FLD_EN   = 2'd2,
        FLD_RSVD = 2'd3
    } cfg_field_e;
endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
    import csd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [2:0]                   cfg_idx,
    input  logic [1:0]                   cfg_field,
    input  logic [ADDR_W-1:0]            cfg_wdata,
    output logic [NREG-1:0][ADDR_W-1:0]  base_q,
    output logic [NREG-1:0][ADDR_W-1:0]  mask_q,
    output logic [NREG-1:0]              en_q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                mask_q[g] <= '0;
                en_q[g]   <= 1'b0;
            end else if (cfg_we && cfg_idx == 3'(g)) begin
                case (cfg_field_e'(cfg_field))
                    FLD_BASE: base_q[g] <= cfg_wdata;
                    FLD_MASK: mask_q[g] <= cfg_wdata;
                    FLD_EN:   en_q[g]   <= cfg_wdata[0];
                    default:  ;
                endcase
            end
        end
    end

    // R12
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_field == 2'(FLD_EN) && cfg_idx != 3'(RG_NONE))
        |=> (en_q[$past(cfg_idx)] == $past(cfg_wdata[0])));
endmodule

// File: rtl/csd_region_match.sv
module csd_region_match
    import csd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         periph_mode,
    input  logic [NREG-1:0][ADDR_W-1:0]  base_q,
    input  logic [NREG-1:0][ADDR_W-1:0]  mask_q,
    input  logic [NREG-1:0]              en_q,
    output logic [NREG-1:0]              hit
);
    for (genvar g = 0; g < NREG; g++) begin : g_hit
        if (g == int'(RG_PIO)) begin : g_gated
            assign hit[g] = periph_mode && en_q[g] && ((addr & mask_q[g]) == base_q[g]);
        end else begin : g_plain
            assign hit[g] = en_q[g] && ((addr & mask_q[g]) == base_q[g]);
        end
    end
endmodule

// File: rtl/csd_cfg_check.sv
module csd_cfg_check
    import csd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BLK_LG = 13
) (
    input  logic                         periph_mode,
    input  logic [NREG-1:0][ADDR_W-1:0]  base_q,
    input  logic [NREG-1:0][ADDR_W-1:0]  mask_q,
    input  logic [NREG-1:0]              en_q,
    output logic                         err_code_ovl,
    output logic                         err_data_ovl,
    output logic                         err_code_size
);
    function automatic logic pair_ovl(input logic [ADDR_W-1:0] bi, input logic [ADDR_W-1:0] mi,
                                      input logic [ADDR_W-1:0] bj, input logic [ADDR_W-1:0] mj);
        return ((bi & ~mi) == '0) && ((bj & ~mj) == '0) && (((bi ^ bj) & mi & mj) == '0);
    endfunction

    logic [NREG-1:0] part;

    always_comb begin
        part = en_q;
        part[RG_PIO] = en_q[RG_PIO] && periph_mode;
    end

    always_comb begin
        err_code_ovl = 1'b0;
        for (int i = 0; i < NCODE; i++) begin
            for (int j = i + 1; j < NCODE; j++) begin
                if (part[i] && part[j] && pair_ovl(base_q[i], mask_q[i], base_q[j], mask_q[j]))
                    err_code_ovl = 1'b1;
            end
        end
    end

    always_comb begin
        err_data_ovl = 1'b0;
        for (int i = NCODE; i < NREG; i++) begin
            for (int j = i + 1; j < NREG; j++) begin
                if (part[i] && part[j] && pair_ovl(base_q[i], mask_q[i], base_q[j], mask_q[j]))
                    err_data_ovl = 1'b1;
            end
        end
    end

    always_comb begin
        err_code_size = 1'b0;
        for (int i = 0; i < NCODE; i++) begin
            if (en_q[i] && ($countones(~mask_q[i]) > BLK_LG))
                err_code_size = 1'b1;
        end
    end
endmodule

// File: rtl/csd_select.sv
module csd_select
    import csd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         dec_en,
    input  logic                         bus16,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NREG-1:0]              hit,
    input  logic [NREG-1:0][ADDR_W-1:0]  mask_q,
    output logic [NREG-1:0]              sel,
    output logic                         no_sel,
    output logic [ADDR_W-1:0]            offset
);
    region_e win;

    always_comb begin
        win = RG_NONE;
        if (dec_en) begin
            for (int i = NCODE - 1; i >= 0; i--) begin
                if (hit[i]) win = region_e'(i);
            end
            if (hit[RG_PIO]) win = RG_PIO;
            if (hit[RG_IIO]) win = RG_IIO;
            if (hit[RG_SRAM]) win = RG_SRAM;
        end
    end

    always_comb begin
        sel    = '0;
        offset = '0;
        if (win != RG_NONE) begin
            sel[win] = 1'b1;
            offset   = (addr & ~mask_q[win]) >> bus16;
        end
        no_sel = dec_en && (hit == '0);
    end

    // R11
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R4
    data_over_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && (hit[NREG-1:NCODE] != '0)) |-> (sel[NCODE-1:0] == '0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |-> (sel == '0 && !no_sel));

    // R10
    nosel_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_sel |-> (hit == '0 && sel == '0));
endmodule

// File: rtl/csd_decoder.sv
module csd_decoder
    import csd_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int CODE_BLK_KB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_idx,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              dec_en,
    input  logic              bus16,
    input  logic              periph_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        code_sel,
    output logic              sram_sel,
    output logic              iio_sel,
    output logic              pio_sel,
    output logic              no_sel,
    output logic [ADDR_W-1:0] offset,
    output logic              err_code_ovl,
    output logic              err_data_ovl,
    output logic              err_code_size
);
    localparam int BLK_BYTES = CODE_BLK_KB * 1024;
    localparam int BLK_LG    = $clog2(BLK_BYTES);

    logic [NREG-1:0][ADDR_W-1:0] base_q;
    logic [NREG-1:0][ADDR_W-1:0] mask_q;
    logic [NREG-1:0]             en_q;
    logic [NREG-1:0]             hit;
    logic [NREG-1:0]             sel;

    csd_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .base_q(base_q), .mask_q(mask_q), .en_q(en_q)
    );

    csd_region_match #(.ADDR_W(ADDR_W)) u_match (
        .addr(addr), .periph_mode(periph_mode),
        .base_q(base_q), .mask_q(mask_q), .en_q(en_q), .hit(hit)
    );

    csd_cfg_check #(.ADDR_W(ADDR_W), .BLK_LG(BLK_LG)) u_check (
        .periph_mode(periph_mode), .base_q(base_q), .mask_q(mask_q), .en_q(en_q),
        .err_code_ovl(err_code_ovl), .err_data_ovl(err_data_ovl),
        .err_code_size(err_code_size)
    );

    csd_select #(.ADDR_W(ADDR_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .bus16(bus16), .addr(addr),
        .hit(hit), .mask_q(mask_q), .sel(sel), .no_sel(no_sel), .offset(offset)
    );

    assign code_sel = sel[NCODE-1:0];
    assign sram_sel = sel[RG_SRAM];
    assign iio_sel  = sel[RG_IIO];
    assign pio_sel  = sel[RG_PIO];

    // R6
    pio_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_mode |-> !pio_sel);
endmodule

// File: tb/csd_decoder_bench.sv
module csd_decoder_bench;
    localparam int AW     = 20;
    localparam int BLK_LG = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [1:0]    cfg_field = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          dec_en = 1'b0;
    logic          bus16 = 1'b0;
    logic          periph_mode = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [3:0]    code_sel;
    logic          sram_sel, iio_sel, pio_sel, no_sel;
    logic [AW-1:0] offset;
    logic          err_code_ovl, err_data_ovl, err_code_size;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [AW-1:0] mb [7];
    logic [AW-1:0] mm [7];
    bit            me [7];

    always #10 clk = ~clk;

    csd_decoder u_csd_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .dec_en(dec_en),
        .bus16(bus16), .periph_mode(periph_mode), .addr(addr),
        .code_sel(code_sel), .sram_sel(sram_sel), .iio_sel(iio_sel),
        .pio_sel(pio_sel), .no_sel(no_sel), .offset(offset),
        .err_code_ovl(err_code_ovl), .err_data_ovl(err_data_ovl),
        .err_code_size(err_code_size)
    );

    function automatic bit ovl(int i, int j);
        return ((mb[i] & ~mm[i]) == '0) && ((mb[j] & ~mm[j]) == '0) &&
               (((mb[i] ^ mb[j]) & mm[i] & mm[j]) == '0);
    endfunction

    function automatic int zeros(logic [AW-1:0] m);
        int n = 0;
        for (int b = 0; b < AW; b++) if (!m[b]) n++;
        return n;
    endfunction

    // model output: {sel[6:0], no_sel, ecode, edata, esize} plus offset
    task automatic expect_out(output logic [6:0] s, output logic ns, output logic [AW-1:0] off,
                              output logic ec, output logic ed, output logic es);
        logic [6:0] h;
        int w;
        bit p [7];
        for (int i = 0; i < 7; i++) begin
            p[i] = me[i] && (i != 6 || periph_mode);
            h[i] = p[i] && ((addr & mm[i]) == mb[i]);
        end
        w = -1;
        if (dec_en) begin
            if (h[4]) w = 4;
            else if (h[5]) w = 5;
            else if (h[6]) w = 6;
            else for (int i = 3; i >= 0; i--) if (h[i]) w = i;
        end
        s = '0;
        off = '0;
        if (w >= 0) begin
            s[w] = 1'b1;
            off = (addr & ~mm[w]) >> (bus16 ? 1 : 0);
        end
        ns = dec_en && (h == '0);
        ec = 1'b0;
        for (int i = 0; i < 4; i++)
            for (int j = i + 1; j < 4; j++)
                if (p[i] && p[j] && ovl(i, j)) ec = 1'b1;
        ed = 1'b0;
        for (int i = 4; i < 7; i++)
            for (int j = i + 1; j < 7; j++)
                if (p[i] && p[j] && ovl(i, j)) ed = 1'b1;
        es = 1'b0;
        for (int i = 0; i < 4; i++)
            if (me[i] && zeros(mm[i]) > BLK_LG) es = 1'b1;
    endtask

    task automatic check(input string tag);
        logic [6:0] s;
        logic ns, ec, ed, es;
        logic [AW-1:0] off;
        logic [6:0] act;
        #2;
        expect_out(s, ns, off, ec, ed, es);
        act = {pio_sel, iio_sel, sram_sel, code_sel};
        total++;
        if (act !== s || no_sel !== ns || offset !== off ||
            err_code_ovl !== ec || err_data_ovl !== ed || err_code_size !== es ||
            $countones(act) > 1) begin
            bad++;
            $display("FAIL %s: sel=%b nosel=%b off=%h err=%b%b%b expected sel=%b nosel=%b off=%h err=%b%b%b",
                     tag, act, no_sel, offset, err_code_ovl, err_data_ovl, err_code_size,
                     s, ns, off, ec, ed, es);
        end
    endtask

    task automatic wr(input int idx, input int fld, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_field = 2'(fld); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 7) begin
            if (fld == 0) mb[idx] = d;
            else if (fld == 1) mm[idx] = d;
            else if (fld == 2) me[idx] = d[0];
        end
    endtask

    task automatic region(input int idx, input logic [AW-1:0] b, input logic [AW-1:0] m);
        wr(idx, 0, b);
        wr(idx, 1, m);
        wr(idx, 2, 1);
    endtask

    task automatic drive(input logic [AW-1:0] a);
        @(negedge clk);
        addr = a;
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 7; i++) begin mb[i] = '0; mm[i] = '0; me[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        dec_en = 1'b1;
        // R1 reset state
        drive(20'h00000); check("R1");
        drive(20'h5A5A5); check("R1");

        // R2 / R8 basic match and offset
        region(0, 20'h00000, 20'hFE000);
        drive(20'h01234); check("R2");
        bus16 = 1'b1; drive(20'h01234); check("R8");
        bus16 = 1'b0;

        // R7 oversize code window, then fixed
        region(1, 20'h04000, 20'hFC000);
        drive(20'h05678); check("R7");
        wr(1, 1, 20'hFE000);
        drive(20'h04010); check("R7");

        // R3 code overlap, lowest index wins
        region(2, 20'h00000, 20'hFF000);
        drive(20'h00100); check("R3");
        wr(2, 0, 20'h10000);
        drive(20'h10100); check("R3");

        // R4 SRAM overlays code block 0
        region(4, 20'h01000, 20'hFF800);
        drive(20'h01010); check("R4");
        bus16 = 1'b1; drive(20'h01010); check("R8");
        bus16 = 1'b0;

        // R5 data overlap and data priority
        region(5, 20'h01000, 20'hFFF00);
        drive(20'h01010); check("R5");
        wr(5, 0, 20'h20000);
        drive(20'h20005); check("R5");

        // R6 peripheral window gated by port mode
        region(6, 20'h30000, 20'hFFF00);
        periph_mode = 1'b0; drive(20'h30001); check("R6");
        periph_mode = 1'b1; drive(20'h30001); check("R6");
        wr(6, 0, 20'h20000);
        periph_mode = 1'b0; drive(20'h20001); check("R6");
        periph_mode = 1'b1; drive(20'h20001); check("R6");
        wr(6, 0, 20'h30000);

        // R9 global disable
        dec_en = 1'b0; drive(20'h01010); check("R9");
        dec_en = 1'b1;

        // R10 no region hits
        drive(20'hF0000); check("R10");

        // R12 ignored index and ignored field
        wr(7, 0, 20'hF0000);
        wr(7, 2, 20'h00001);
        drive(20'hF0000); check("R12");
        wr(0, 3, 20'hFFFFF);
        drive(20'h00200); check("R12");
        wr(0, 2, 20'h00000);
        drive(20'h00200); check("R12");

        // R11 random configurations and addresses
        for (int it = 0; it < 400; it++) begin
            int idx = $urandom_range(0, 6);
            int k = $urandom_range(8, 16);
            logic [AW-1:0] m = 20'hFFFFF << k;
            logic [AW-1:0] a;
            region(idx, AW'($urandom) & m, m);
            if ($urandom_range(0, 5) == 0) wr(idx, 2, 0);
            dec_en = ($urandom_range(0, 9) != 0);
            bus16 = 1'($urandom);
            periph_mode = 1'($urandom);
            for (int r = 0; r < 4; r++) begin
                int t = $urandom_range(0, 6);
                if ($urandom_range(0, 1) == 1) a = mb[t] | (AW'($urandom) & ~mm[t]);
                else a = AW'($urandom);
                drive(a); check("R11");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule